// File: doc/BRIEF.md
# Shadowed-Read Real-Time Clock

This peripheral keeps wall-clock time from a 32 768 Hz tick enable and exposes it through a simple synchronous register bus. The bus has a byte address, a write strobe, a read strobe, and 32-bit write and read data. A 32-bit seconds counter and a 0..999 millisecond counter advance through a fractional accumulator. Every eighth tick, both counters are copied into the bus-visible time registers. A busy flag marks the tick interval that ends in that copy, so software can place its writes away from it.

A bus read of the visible millisecond register also latches the visible seconds into a shadow register. Reading milliseconds first and then the shadow seconds therefore gives one coherent timestamp. The block also has:
- two seconds alarms and one millisecond alarm;
- a write-1-to-clear interrupt status with a per-bit mask;
- a level-high interrupt output.

Top module: `rtc_shadow_top`

## Requirements
- R1: Each tick adds 1000 to a 15-bit accumulator modulo 32768, and each wrap advances the millisecond count. After T ticks with no seconds load, milliseconds = floor(T*1000/32768) mod 1000. Seconds = the loaded value + floor(T*1000/32768)/1000, wrapping modulo 2^32.
- R2: Bit 0 at offset 0x004 reads 1 exactly while the tick count since reset, modulo 8, equals 7. At the tick that ends that interval, the live seconds and milliseconds are copied to offsets 0x008 and 0x010. Between copies those two offsets hold their values.
- R3: A read strobe with address 0x010 latches the current visible seconds (0x008) into the shadow register at offset 0x00C.
- R4: A write to 0x008 loads seconds, clears the milliseconds and the accumulator, and takes priority over a tick in the same cycle. It leaves the copy cadence unchanged, so the visible copy shows the new value only after the next copy tick.
- R5: Seconds alarms at 0x014 and 0x018 are disabled when zero. When the seconds counter takes a value equal to a nonzero alarm, by a tick or by a load, status bit 0 (alarm at 0x014) or bit 1 (alarm at 0x018) is set.
- R6: The 10-bit millisecond alarm at 0x01C sets status bit 2 when a tick-driven millisecond step reaches its value.
- R7: Status at 0x02C: writing 1 to a bit clears it and writing 0 leaves it. A set event in the same cycle wins over the clear. Bits 3 and 4 (countdown positions) never set.
- R8: The 5-bit mask at 0x028 uses the same bit layout. The interrupt output is high whenever any status bit and its mask bit are both 1.
- R9: Reset clears counters, copies, shadow, alarms, mask and status. Unmapped offsets read 0. Writes to unmapped offsets and to 0x004, 0x00C and 0x010 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_32k | input | 1 | One-cycle enable at 32 768 Hz |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe (drives shadow capture) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, same cycle |
| irq | output | 1 | Level-high interrupt |

## Verification
The bench aims at the cycle where a status write-1-to-clear meets a millisecond carry that matches the alarm. A design that let the clear win would lose that interrupt. It writes seconds during a busy interval and checks that the visible copy holds the old value until the next copy. A design that copied on every write, or that restarted the cadence on a write, would show the new value too early or move the busy window. It reads milliseconds and then shadow seconds at random phases, where a shadow taken from the live counter would disagree with the returned milliseconds. It also runs seconds across 2^32 and pokes read-only and unmapped offsets. A wrong carry would show as a stuck or skipped count. A decode that ignored read-only offsets incorrectly would show as a corrupted counter.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int OFF_BUSY   = 'h004;
  localparam int OFF_SEC    = 'h008;
  localparam int OFF_SHADOW = 'h00C;
  localparam int OFF_MSEC   = 'h010;
  localparam int OFF_ALM0   = 'h014;
  localparam int OFF_ALM1   = 'h018;
  localparam int OFF_MALM   = 'h01C;
  localparam int OFF_MASK   = 'h028;
  localparam int OFF_STAT   = 'h02C;

  localparam int EV_W       = 5;
  localparam int EV_SALM0   = 0;
  localparam int EV_SALM1   = 1;
  localparam int EV_MALM    = 2;
  localparam int EV_SCDN    = 3;
  localparam int EV_MCDN    = 4;
endpackage

// File: rtl/rtc_timebase.sv
module rtc_timebase #(
  parameter int MS_STEP    = 1000,
  parameter int ACC_MOD    = 32768,
  parameter int MS_LIMIT   = 1000,
  parameter int COPY_TICKS = 8,
  parameter int SEC_W      = 32,
  localparam int MS_W      = $clog2(MS_LIMIT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic [SEC_W-1:0] load_val,
  output logic [SEC_W-1:0] sec,
  output logic [SEC_W-1:0] sec_nxt,
  output logic [MS_W-1:0]  ms,
  output logic [MS_W-1:0]  ms_nxt,
  output logic             sec_evt,
  output logic             ms_evt,
  output logic             busy,
  output logic             copy_evt,
  output logic [SEC_W-1:0] vis_sec,
  output logic [MS_W-1:0]  vis_ms
);
  localparam int ACC_W = $clog2(ACC_MOD);
  localparam int PH_W  = (COPY_TICKS > 1) ? $clog2(COPY_TICKS) : 1;
  localparam logic [ACC_W:0]  STEP_V = (ACC_W+1)'(MS_STEP);
  localparam logic [ACC_W:0]  MOD_V  = (ACC_W+1)'(ACC_MOD);
  localparam logic [MS_W-1:0] MS_TOP = MS_W'(MS_LIMIT - 1);
  localparam logic [PH_W-1:0] PH_TOP = PH_W'(COPY_TICKS - 1);

  // {carry, next accumulator}
  function automatic logic [ACC_W:0] acc_step(input logic [ACC_W-1:0] a);
    logic [ACC_W:0] s;
    s = {1'b0, a} + STEP_V;
    if (s >= MOD_V) acc_step = {1'b1, ACC_W'(s - MOD_V)};
    else            acc_step = {1'b0, s[ACC_W-1:0]};
  endfunction

  // {wrap, next millisecond}
  function automatic logic [MS_W:0] ms_step(input logic [MS_W-1:0] m);
    if (m == MS_TOP) ms_step = {1'b1, {MS_W{1'b0}}};
    else             ms_step = {1'b0, m + MS_W'(1)};
  endfunction

  logic [ACC_W-1:0] acc;
  logic [PH_W-1:0]  phase;
  logic [ACC_W:0]   acc_res;
  logic [MS_W:0]    ms_res;
  logic             carry, ms_wrap;

  assign acc_res  = acc_step(acc);
  assign carry    = acc_res[ACC_W];
  assign ms_res   = ms_step(ms);
  assign ms_wrap  = ms_res[MS_W];
  assign ms_evt   = tick && !load && carry;
  assign sec_evt  = load || (ms_evt && ms_wrap);
  assign busy     = (phase == PH_TOP);
  assign copy_evt = tick && busy;

  always_comb begin
    sec_nxt = sec;
    ms_nxt  = ms;
    if (load) begin
      sec_nxt = load_val;
      ms_nxt  = '0;
    end else if (ms_evt) begin
      ms_nxt = ms_res[MS_W-1:0];
      if (ms_wrap) sec_nxt = sec + SEC_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc     <= '0;
      sec     <= '0;
      ms      <= '0;
      phase   <= '0;
      vis_sec <= '0;
      vis_ms  <= '0;
    end else begin
      sec <= sec_nxt;
      ms  <= ms_nxt;
      if (load)      acc <= '0;
      else if (tick) acc <= acc_res[ACC_W-1:0];
      if (tick) phase <= busy ? '0 : phase + PH_W'(1);
      if (copy_evt) begin
        vis_sec <= sec;
        vis_ms  <= ms;
      end
    end
  end

  p_ms_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ms <= MS_TOP);
  p_sec_carry_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && carry && ms == MS_TOP) |=> (sec == $past(sec) + SEC_W'(1)) && (ms == '0));
  p_vis_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !copy_evt |=> $stable(vis_sec) && $stable(vis_ms));
  p_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (sec == $past(load_val)) && (ms == '0) && (acc == '0));
endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp #(
  parameter int SEC_W = 32,
  parameter int MS_W  = 10,
  parameter int EV_W  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sec_evt,
  input  logic [SEC_W-1:0] sec_nxt,
  input  logic             ms_evt,
  input  logic [MS_W-1:0]  ms_nxt,
  input  logic [SEC_W-1:0] alm0,
  input  logic [SEC_W-1:0] alm1,
  input  logic [MS_W-1:0]  malm,
  output logic [EV_W-1:0]  set_vec
);
  import rtc_pkg::*;

  function automatic logic sec_hit(input logic ev, input logic [SEC_W-1:0] v,
                                   input logic [SEC_W-1:0] a);
    sec_hit = ev && (a != '0) && (v == a);
  endfunction

  always_comb begin
    set_vec           = '0;
    set_vec[EV_SALM0] = sec_hit(sec_evt, sec_nxt, alm0);
    set_vec[EV_SALM1] = sec_hit(sec_evt, sec_nxt, alm1);
    set_vec[EV_MALM]  = ms_evt && (ms_nxt == malm);
  end

  p_alarm_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (alm0 == '0) |-> !set_vec[EV_SALM0]);
  p_malm_needs_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ms_evt |-> !set_vec[EV_MALM]);
endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl #(
  parameter int EV_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [EV_W-1:0] set_vec,
  input  logic            clr_we,
  input  logic [EV_W-1:0] clr_bits,
  input  logic            mask_we,
  input  logic [EV_W-1:0] mask_wdata,
  output logic [EV_W-1:0] status,
  output logic [EV_W-1:0] mask,
  output logic            irq
);
  import rtc_pkg::*;

  logic [EV_W-1:0] clr_eff;
  assign clr_eff = clr_we ? clr_bits : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status <= '0;
      mask   <= '0;
    end else begin
      status <= (status & ~clr_eff) | set_vec;
      if (mask_we) mask <= mask_wdata;
    end
  end

  assign irq = |(status & mask);

  p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec) |=> ((status & $past(set_vec)) == $past(set_vec)));
  p_cdn_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !status[EV_SCDN] && !status[EV_MCDN]);
  p_irq_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(|set_vec) || $past(mask_we)));
endmodule

// File: rtl/rtc_shadow_top.sv
module rtc_shadow_top #(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  parameter int MS_STEP    = 1000,
  parameter int ACC_MOD    = 32768,
  parameter int MS_LIMIT   = 1000,
  parameter int COPY_TICKS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_32k,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  import rtc_pkg::*;
  localparam int MS_W = $clog2(MS_LIMIT);

  logic [DATA_W-1:0] sec, sec_nxt, vis_sec, shadow, alm0, alm1;
  logic [MS_W-1:0]   ms, ms_nxt, vis_ms, malm;
  logic              sec_evt, ms_evt, busy, copy_evt;
  logic [EV_W-1:0]   set_vec, status, mask;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int off);
    hit = (a == ADDR_W'(off));
  endfunction

  logic wr_sec, wr_alm0, wr_alm1, wr_malm, wr_mask, wr_stat, rd_msec;
  assign wr_sec  = bus_we && hit(bus_addr, OFF_SEC);
  assign wr_alm0 = bus_we && hit(bus_addr, OFF_ALM0);
  assign wr_alm1 = bus_we && hit(bus_addr, OFF_ALM1);
  assign wr_malm = bus_we && hit(bus_addr, OFF_MALM);
  assign wr_mask = bus_we && hit(bus_addr, OFF_MASK);
  assign wr_stat = bus_we && hit(bus_addr, OFF_STAT);
  assign rd_msec = bus_re && hit(bus_addr, OFF_MSEC);

  rtc_timebase #(
    .MS_STEP(MS_STEP), .ACC_MOD(ACC_MOD), .MS_LIMIT(MS_LIMIT),
    .COPY_TICKS(COPY_TICKS), .SEC_W(DATA_W)
  ) u_time (
    .clk(clk), .rst_n(rst_n), .tick(tick_32k), .load(wr_sec), .load_val(bus_wdata),
    .sec(sec), .sec_nxt(sec_nxt), .ms(ms), .ms_nxt(ms_nxt),
    .sec_evt(sec_evt), .ms_evt(ms_evt), .busy(busy), .copy_evt(copy_evt),
    .vis_sec(vis_sec), .vis_ms(vis_ms)
  );

  rtc_alarm_cmp #(.SEC_W(DATA_W), .MS_W(MS_W), .EV_W(EV_W)) u_alarm (
    .clk(clk), .rst_n(rst_n), .sec_evt(sec_evt), .sec_nxt(sec_nxt),
    .ms_evt(ms_evt), .ms_nxt(ms_nxt), .alm0(alm0), .alm1(alm1), .malm(malm),
    .set_vec(set_vec)
  );

  rtc_irq_ctrl #(.EV_W(EV_W)) u_irq (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec),
    .clr_we(wr_stat), .clr_bits(bus_wdata[EV_W-1:0]),
    .mask_we(wr_mask), .mask_wdata(bus_wdata[EV_W-1:0]),
    .status(status), .mask(mask), .irq(irq)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      alm0   <= '0;
      alm1   <= '0;
      malm   <= '0;
      shadow <= '0;
    end else begin
      if (wr_alm0) alm0 <= bus_wdata;
      if (wr_alm1) alm1 <= bus_wdata;
      if (wr_malm) malm <= bus_wdata[MS_W-1:0];
      if (rd_msec) shadow <= vis_sec;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if      (hit(bus_addr, OFF_BUSY))   bus_rdata[0] = busy;
    else if (hit(bus_addr, OFF_SEC))    bus_rdata = vis_sec;
    else if (hit(bus_addr, OFF_SHADOW)) bus_rdata = shadow;
    else if (hit(bus_addr, OFF_MSEC))   bus_rdata[MS_W-1:0] = vis_ms;
    else if (hit(bus_addr, OFF_ALM0))   bus_rdata = alm0;
    else if (hit(bus_addr, OFF_ALM1))   bus_rdata = alm1;
    else if (hit(bus_addr, OFF_MALM))   bus_rdata[MS_W-1:0] = malm;
    else if (hit(bus_addr, OFF_MASK))   bus_rdata[EV_W-1:0] = mask;
    else if (hit(bus_addr, OFF_STAT))   bus_rdata[EV_W-1:0] = status;
  end

  p_shadow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_msec |=> (shadow == $past(vis_sec)));
  p_shadow_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_msec |=> $stable(shadow));
  p_ro_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !wr_sec && !tick_32k) |=> $stable(sec) && $stable(ms));
endmodule

// File: tb/tb_rtc_shadow_top.sv
module tb_rtc_shadow_top;
  localparam int A_BUSY = 'h04, A_SEC = 'h08, A_SHD = 'h0C, A_MS = 'h10;
  localparam int A_AL0 = 'h14, A_AL1 = 'h18, A_MAL = 'h1C, A_MSK = 'h28, A_ST = 'h2C;

  logic clk = 0, rst_n = 0, tick_32k = 0, bus_we = 0, bus_re = 0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic irq;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rtc_shadow_top dut (.clk(clk), .rst_n(rst_n), .tick_32k(tick_32k), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_re(bus_re), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

  // reference state
  longint m_T, m_k;
  logic [31:0] m_base, m_vsec, m_shd, m_al0, m_al1;
  int m_vms;
  logic [9:0] m_mal;
  logic [4:0] m_msk, m_st;

  function automatic longint tot_ms(longint t); return (t * 1000) / 32768; endfunction
  function automatic int cur_ms(); return int'(tot_ms(m_T) % 1000); endfunction
  function automatic logic [31:0] cur_sec(); return m_base + 32'(tot_ms(m_T) / 1000); endfunction

  function automatic logic [31:0] exp_read(int a);
    case (a)
      A_BUSY: return {31'b0, (m_k % 8) == 7};
      A_SEC:  return m_vsec;
      A_SHD:  return m_shd;
      A_MS:   return 32'(m_vms);
      A_AL0:  return m_al0;
      A_AL1:  return m_al1;
      A_MAL:  return {22'b0, m_mal};
      A_MSK:  return {27'b0, m_msk};
      A_ST:   return {27'b0, m_st};
      default: return 32'h0;
    endcase
  endfunction

  task automatic model_reset();
    m_T = 0; m_k = 0; m_base = 0; m_vsec = 0; m_shd = 0; m_al0 = 0; m_al1 = 0;
    m_vms = 0; m_mal = 0; m_msk = 0; m_st = 0;
  endtask

  task automatic model_edge(bit tk, bit we, bit re, int a, logic [31:0] d);
    longint t0 = tot_ms(m_T), t1;
    logic [31:0] s0 = cur_sec(), s1;
    logic [4:0] setv = '0, clr = '0;
    int ms1;
    if (re && a == A_MS) m_shd = m_vsec;
    if (tk && (m_k % 8) == 7) begin m_vsec = s0; m_vms = int'(t0 % 1000); end
    if (we && a == A_SEC) begin
      m_base = d; m_T = 0;
      if (m_al0 != 0 && d == m_al0) setv[0] = 1;
      if (m_al1 != 0 && d == m_al1) setv[1] = 1;
    end else if (tk) begin
      m_T++;
      t1 = tot_ms(m_T);
      if (t1 != t0) begin
        ms1 = int'(t1 % 1000);
        if (ms1 == int'(m_mal)) setv[2] = 1;
        s1 = cur_sec();
        if (s1 != s0) begin
          if (m_al0 != 0 && s1 == m_al0) setv[0] = 1;
          if (m_al1 != 0 && s1 == m_al1) setv[1] = 1;
        end
      end
    end
    if (tk) m_k++;
    if (we && a == A_ST) clr = d[4:0];
    m_st = (m_st & ~clr) | setv;
    if (we && a == A_AL0) m_al0 = d;
    if (we && a == A_AL1) m_al1 = d;
    if (we && a == A_MAL) m_mal = d[9:0];
    if (we && a == A_MSK) m_msk = d[4:0];
  endtask

  task automatic fail(string req, logic [31:0] act, logic [31:0] exp, string what);
    failures++;
    $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
  endtask

  // one bus cycle: drive at negedge, sample before posedge, update reference after it
  task automatic step(bit tk, bit we, bit re, int a, logic [31:0] d, string req, bit chk);
    logic [31:0] exp_rd;
    logic exp_irq;
    @(negedge clk);
    tick_32k = tk; bus_we = we; bus_re = re; bus_addr = 8'(a); bus_wdata = d;
    #1;
    exp_rd = exp_read(a);
    exp_irq = |(m_st & m_msk);
    checks++;
    if (irq !== exp_irq) fail("R8", {31'b0, irq}, {31'b0, exp_irq}, "irq level");
    if (chk) begin
      checks++;
      if (bus_rdata !== exp_rd) fail(req, bus_rdata, exp_rd, $sformatf("read @%h", a));
    end
    @(posedge clk);
    model_edge(tk, we, re, a, d);
  endtask

  task automatic rd(int a, string req, bit tk = 0); step(tk, 0, 1, a, 0, req, 1); endtask
  task automatic wr(int a, logic [31:0] d, bit tk = 0); step(tk, 1, 0, a, d, "", 0); endtask
  task automatic idle(bit tk); step(tk, 0, 0, 0, 0, "", 0); endtask
  task automatic ticks(int n); for (int i = 0; i < n; i++) idle(1); endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int addrs[12] = '{A_BUSY, A_SEC, A_SHD, A_MS, A_AL0, A_AL1, A_MAL, A_MSK, A_ST, 'h00, 'h20, 'h30};
    void'($urandom(32'd4711));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;

    // R9: reset values and unmapped reads
    foreach (addrs[i]) rd(addrs[i], "R9");

    // R1/R2: count and periodic copy, busy window
    for (int i = 0; i < 80; i++) begin rd(A_BUSY, "R2", 1); end
    rd(A_SEC, "R1"); rd(A_MS, "R1");

    // R3: shadow latches visible seconds on millisecond read
    wr(A_SEC, 32'd41); ticks(20);
    rd(A_MS, "R3"); rd(A_SHD, "R3");

    // R4: load during busy, visible copy lags until next copy tick
    while ((m_k % 8) != 7) idle(1);
    wr(A_SEC, 32'd900);
    rd(A_SEC, "R4"); idle(1); rd(A_SEC, "R4"); rd(A_MS, "R4");
    ticks(8); rd(A_SEC, "R4"); rd(A_MS, "R4");
    // R4: load wins over a same-cycle tick
    step(1, 1, 0, A_SEC, 32'd77, "", 0); ticks(8); rd(A_SEC, "R4"); rd(A_MS, "R4");

    // R5: zero alarm disabled, nonzero alarm set by load; R8 mask; R7 clear
    wr(A_SEC, 32'd0); rd(A_ST, "R5");
    wr(A_AL0, 32'd55); wr(A_AL1, 32'd56); wr(A_MSK, 32'h3);
    wr(A_SEC, 32'd55); rd(A_ST, "R5");
    wr(A_ST, 32'h1); rd(A_ST, "R7");
    wr(A_SEC, 32'd56); rd(A_ST, "R5"); wr(A_ST, 32'h0); rd(A_ST, "R7");
    wr(A_ST, 32'h1F); rd(A_ST, "R7"); wr(A_MSK, 32'h0);

    // R6: millisecond alarm by tick
    wr(A_SEC, 32'd3); wr(A_MAL, 32'd5); ticks(200); rd(A_ST, "R6");
    wr(A_ST, 32'h1F);

    // R7: set beats clear in the same cycle
    wr(A_MAL, 32'(cur_ms() + 1));
    while (tot_ms(m_T + 1) == tot_ms(m_T)) idle(1);
    step(1, 1, 0, A_ST, 32'h1F, "", 0);
    checks++;
    if (m_st[2] !== 1'b1) fail("R7", {27'b0, m_st}, 32'h4, "reference set-wins");
    rd(A_ST, "R7");
    wr(A_ST, 32'h1F);

    // R9: read-only and unmapped writes ignored
    wr(A_SEC, 32'd1234); ticks(8);
    wr(A_BUSY, 32'hFFFF_FFFF); wr(A_SHD, 32'hFFFF_FFFF); wr(A_MS, 32'h3FF);
    wr('h20, 32'hFFFF_FFFF); wr('h30, 32'hFFFF_FFFF);
    ticks(8);
    foreach (addrs[i]) rd(addrs[i], "R9");

    // R1: 32-bit seconds wrap
    wr(A_SEC, 32'hFFFF_FFFF); ticks(32800);
    rd(A_SEC, "R1"); rd(A_MS, "R1");

    // random mix, all reads against the reference
    for (int i = 0; i < 5000; i++) begin
      int r = int'($urandom_range(0, 99));
      bit tk = 1'($urandom_range(0, 1));
      int a = addrs[$urandom_range(0, 11)];
      if (r < 45) rd(a, "R2", tk);
      else if (r < 60) begin
        int w = int'($urandom_range(0, 6));
        case (w)
          0: wr(A_SEC, 32'($urandom_range(10, 14)), tk);
          1: wr(A_AL0, 32'($urandom_range(0, 14)), tk);
          2: wr(A_AL1, 32'($urandom_range(0, 14)), tk);
          3: wr(A_MAL, 32'($urandom_range(0, 40)), tk);
          4: wr(A_MSK, 32'($urandom), tk);
          5: wr(A_ST, 32'($urandom), tk);
          default: wr(a, $urandom, tk);
        endcase
      end else idle(tk);
    end
    rd(A_MS, "R3"); rd(A_SHD, "R3");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule